// File: doc/BRIEF.md
# SD UHS-I Signalling Voltage Switch Sequencer

This block sits inside an SD host controller and runs the part of card initialization that moves the bus from 3.3 V to 1.8 V signalling. On a start pulse it forms the operating-condition argument from the host's speed-mode and supply capabilities. It then hands that argument to the command engine as the application operating-condition command (index 41). If the card answers that it is high capacity and accepts the 1.8 V request, the block issues the voltage-switch command (index 11) and gates the card clock. It checks that the data lines have gone low, raises the 1.8 V signalling enable and waits a timed interval with the clock stopped. It then restarts the clock and, after a second interval, confirms that the card drives all data lines high.

Any failure in the line checks or in the regulator readback powers the card down and reports a retry. The next attempt is then made with the 1.8 V request withdrawn, so the card comes up at 3.3 V. A rejected command reports a command error and leaves power alone. Each attempt ends with a one-cycle done pulse that carries a two-bit result. The waits come from a millisecond prescaler whose length in clock cycles is a parameter.

Top module: `sd_vswitch_seq`

## Requirements
- R1: After reset, card_pwr_en and card_clk_en are 1, and sig18_en, cmd_req and done are 0.
- R2: Bit 24 of the operating-condition argument is 1 when any bit of uhs_cap is set and no retry is pending. It is 0 otherwise.
- R3: Bit 28 of the argument is 1 when some rail i has rail_cap[i] set and max_cur field i times 4 exceeds 150 mA. Field i is max_cur[8i+7:8i]; rail 0 is 3.3 V, rail 1 is 3.0 V and rail 2 is 1.8 V. Bit 30 is always 1. Rail 0 adds bits 21:20, rail 1 adds bits 18:17 and rail 2 adds bit 7. The request uses cmd_idx 41 and cmd_req stays high until cmd_ack.
- R4: The switch starts only when the response has both bit 30 and bit 24 set, spi_mode is 0, and bit 24 was sent. In every other case the attempt ends with status OK and no index-11 command.
- R5: The switch command uses cmd_idx 11 with argument 0. If cmd_err is set with any acknowledge, or the index-11 response has any of bits 31:19 set, the attempt ends with status CMDERR and card power stays on.
- R6: After a clean index-11 response, card_clk_en drops. If dat_lvl is not 0000 in the next cycle, the attempt fails.
- R7: sig18_en rises while the clock is gated. The clock then stays off for exactly 5*CYC_PER_MS cycles. If v18_good is low at the end of that time, the attempt fails.
- R8: The clock is restored, and done follows exactly CYC_PER_MS cycles later. The status is OK only if dat_lvl reads 1111 at that point; otherwise the attempt fails.
- R9: A failed attempt ends with status RETRY and card_pwr_en, card_clk_en and sig18_en all 0. The next attempt sends bit 24 as 0. An OK result clears the pending retry.
- R10: done is a single-cycle pulse. status encodes 01 OK, 10 RETRY and 11 CMDERR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin one initialization attempt |
| spi_mode | input | 1 | Host runs the card in SPI mode |
| uhs_cap | input | 3 | Host ultra-high-speed mode support flags |
| rail_cap | input | 3 | Supply capability: 3.3 V, 3.0 V, 1.8 V |
| max_cur | input | 24 | Three 8-bit max-current fields, 4 mA units |
| cmd_req | output | 1 | Command request to the command engine |
| cmd_idx | output | 6 | Command index |
| cmd_arg | output | 32 | Command argument |
| cmd_ack | input | 1 | Response valid pulse |
| cmd_err | input | 1 | Transport error with the response |
| cmd_resp | input | 32 | Response payload |
| card_clk_en | output | 1 | Card clock enable |
| card_pwr_en | output | 1 | Card power enable |
| sig18_en | output | 1 | 1.8 V signalling enable |
| v18_good | input | 1 | Regulator keeps the 1.8 V enable in force |
| dat_lvl | input | 4 | Sampled DAT[3:0] levels |
| done | output | 1 | Attempt finished pulse |
| status | output | 2 | Result code, valid with done |

## Verification
The bench probes the 150 mA threshold with fields of 37 and 38. A design that compared with greater-or-equal, or that ignored the rail capability, would set bit 28 wrongly. Responses with only one of the two acceptance bits, or with SPI mode on, must not lead to the switch command; a design that tested either bit alone would gate the clock by mistake. The bench counts the gated-clock and restored-clock windows cycle by cycle, so an off-by-one in the prescaler shows up. Each of the three failure points, plus an R1 error bit, is driven separately, and the retry that follows must come back with bit 24 clear. A design that forgot the pending retry, or never cleared it, would send the wrong argument.

// File: rtl/uvs_pkg.sv
package uvs_pkg;

    typedef enum logic [1:0] {
        RES_NONE   = 2'b00,
        RES_OK     = 2'b01,
        RES_RETRY  = 2'b10,
        RES_CMDERR = 2'b11
    } res_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_OPCOND,
        S_SWCMD,
        S_CHKLOW,
        S_WAIT5,
        S_WAIT1,
        S_FAIL
    } seq_e;

    localparam logic [5:0]  CMD_OPCOND   = 6'd41;
    localparam logic [5:0]  CMD_VSWITCH  = 6'd11;
    localparam logic [31:0] RESP_ACCEPT  = 32'h4100_0000;
    localparam logic [31:0] R1_ERR_MASK  = 32'hFFF8_0000;
    localparam int          BIT_S18R     = 24;
    localparam int          BIT_XPC      = 28;
    localparam int          BIT_HCS      = 30;
    localparam logic [3:0]  WAIT_LONG_MS = 4'd5;
    localparam logic [3:0]  WAIT_SHORT_MS = 4'd1;

    // Voltage window bits contributed by each supply rail
    function automatic logic [23:0] rail_window(int idx);
        case (idx)
            0:       return 24'h30_0000;
            1:       return 24'h06_0000;
            2:       return 24'h00_0080;
            default: return 24'h00_0000;
        endcase
    endfunction

    function automatic logic rail_strong(logic [7:0] field, int step, int limit_ma);
        return (32'(field) * 32'(step)) > 32'(limit_ma);
    endfunction

endpackage

// File: rtl/uvs_arg_build.sv
module uvs_arg_build
    import uvs_pkg::*;
#(
    parameter int RAILS    = 3,
    parameter int FIELD_W  = 8,
    parameter int UHS_W    = 3,
    parameter int MA_STEP  = 4,
    parameter int MA_LIMIT = 150
) (
    input  logic [UHS_W-1:0]         uhs_cap,
    input  logic [RAILS-1:0]         rail_cap,
    input  logic [RAILS*FIELD_W-1:0] max_cur,
    input  logic                     retry_pend,
    output logic [31:0]              arg,
    output logic                     s18r
);
    logic [RAILS-1:0] rail_hi;
    logic [23:0]      win_part [RAILS];

    for (genvar i = 0; i < RAILS; i++) begin : g_rail
        assign rail_hi[i]  = rail_cap[i] &&
                             rail_strong(max_cur[i*FIELD_W +: FIELD_W], MA_STEP, MA_LIMIT);
        assign win_part[i] = rail_cap[i] ? rail_window(i) : 24'h0;
    end

    always_comb begin
        logic [23:0] win;
        win = '0;
        for (int i = 0; i < RAILS; i++) win |= win_part[i];
        s18r = (|uhs_cap) && !retry_pend;
        arg  = {8'h00, win};
        arg[BIT_HCS]  = 1'b1;
        arg[BIT_XPC]  = |rail_hi;
        arg[BIT_S18R] = s18r;
    end
endmodule

// File: rtl/uvs_ms_timer.sv
module uvs_ms_timer #(
    parameter int CYC_PER_MS = 125000,
    parameter int MS_W       = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [MS_W-1:0] load_ms,
    output logic            expire
);
    localparam int TW = (CYC_PER_MS > 1) ? $clog2(CYC_PER_MS) : 1;
    localparam logic [TW-1:0] LAST = TW'(CYC_PER_MS - 1);

    logic [TW-1:0]   tick_q;
    logic [MS_W-1:0] ms_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tick_q <= '0;
            ms_q   <= '0;
        end else if (load) begin
            tick_q <= '0;
            ms_q   <= load_ms;
        end else if (ms_q != '0) begin
            if (tick_q == LAST) begin
                tick_q <= '0;
                ms_q   <= ms_q - 1'b1;
            end else begin
                tick_q <= tick_q + 1'b1;
            end
        end
    end

    assign expire = (ms_q == MS_W'(1)) && (tick_q == LAST);
endmodule

// File: rtl/sd_vswitch_seq.sv
module sd_vswitch_seq
    import uvs_pkg::*;
#(
    parameter int CYC_PER_MS = 125000,
    parameter int MA_STEP    = 4,
    parameter int MA_LIMIT   = 150
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        spi_mode,
    input  logic [2:0]  uhs_cap,
    input  logic [2:0]  rail_cap,
    input  logic [23:0] max_cur,
    output logic        cmd_req,
    output logic [5:0]  cmd_idx,
    output logic [31:0] cmd_arg,
    input  logic        cmd_ack,
    input  logic        cmd_err,
    input  logic [31:0] cmd_resp,
    output logic        card_clk_en,
    output logic        card_pwr_en,
    output logic        sig18_en,
    input  logic        v18_good,
    input  logic [3:0]  dat_lvl,
    output logic        done,
    output logic [1:0]  status
);
    localparam int MS_W = 4;

    seq_e        state_q;
    res_e        res_q;
    logic        retry_q;
    logic        s18_sent_q;
    logic [31:0] built_arg;
    logic        built_s18r;
    logic        tmr_load;
    logic [MS_W-1:0] tmr_ms;
    logic        tmr_exp;
    logic        dat_low;
    logic        dat_high;

    assign dat_low  = (dat_lvl == 4'b0000);
    assign dat_high = (dat_lvl == 4'b1111);

    uvs_arg_build #(
        .RAILS(3), .FIELD_W(8), .UHS_W(3), .MA_STEP(MA_STEP), .MA_LIMIT(MA_LIMIT)
    ) u_arg (
        .uhs_cap(uhs_cap), .rail_cap(rail_cap), .max_cur(max_cur),
        .retry_pend(retry_q), .arg(built_arg), .s18r(built_s18r)
    );

    always_comb begin
        tmr_load = 1'b0;
        tmr_ms   = WAIT_LONG_MS;
        if (state_q == S_CHKLOW && dat_low) begin
            tmr_load = 1'b1;
        end else if (state_q == S_WAIT5 && tmr_exp && v18_good) begin
            tmr_load = 1'b1;
            tmr_ms   = WAIT_SHORT_MS;
        end
    end

    uvs_ms_timer #(.CYC_PER_MS(CYC_PER_MS), .MS_W(MS_W)) u_tmr (
        .clk(clk), .rst(rst), .load(tmr_load), .load_ms(tmr_ms), .expire(tmr_exp)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= S_IDLE;
            res_q       <= RES_NONE;
            retry_q     <= 1'b0;
            s18_sent_q  <= 1'b0;
            cmd_req     <= 1'b0;
            cmd_idx     <= '0;
            cmd_arg     <= '0;
            card_clk_en <= 1'b1;
            card_pwr_en <= 1'b1;
            sig18_en    <= 1'b0;
            done        <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state_q)
                S_IDLE: if (start) begin
                    card_pwr_en <= 1'b1;
                    card_clk_en <= 1'b1;
                    sig18_en    <= 1'b0;
                    cmd_req     <= 1'b1;
                    cmd_idx     <= CMD_OPCOND;
                    cmd_arg     <= built_arg;
                    s18_sent_q  <= built_s18r;
                    state_q     <= S_OPCOND;
                end
                S_OPCOND: if (cmd_ack) begin
                    cmd_req <= 1'b0;
                    if (cmd_err) begin
                        done <= 1'b1; res_q <= RES_CMDERR; state_q <= S_IDLE;
                    end else if (!spi_mode && s18_sent_q &&
                                 ((cmd_resp & RESP_ACCEPT) == RESP_ACCEPT)) begin
                        cmd_req <= 1'b1;
                        cmd_idx <= CMD_VSWITCH;
                        cmd_arg <= '0;
                        state_q <= S_SWCMD;
                    end else begin
                        done <= 1'b1; res_q <= RES_OK; retry_q <= 1'b0; state_q <= S_IDLE;
                    end
                end
                S_SWCMD: if (cmd_ack) begin
                    cmd_req <= 1'b0;
                    if (cmd_err || ((cmd_resp & R1_ERR_MASK) != '0)) begin
                        done <= 1'b1; res_q <= RES_CMDERR; state_q <= S_IDLE;
                    end else begin
                        card_clk_en <= 1'b0;
                        state_q     <= S_CHKLOW;
                    end
                end
                S_CHKLOW: begin
                    if (dat_low) begin
                        sig18_en <= 1'b1;
                        state_q  <= S_WAIT5;
                    end else begin
                        state_q  <= S_FAIL;
                    end
                end
                S_WAIT5: if (tmr_exp) begin
                    if (v18_good) begin
                        card_clk_en <= 1'b1;
                        state_q     <= S_WAIT1;
                    end else begin
                        state_q     <= S_FAIL;
                    end
                end
                S_WAIT1: if (tmr_exp) begin
                    if (dat_high) begin
                        done <= 1'b1; res_q <= RES_OK; retry_q <= 1'b0; state_q <= S_IDLE;
                    end else begin
                        state_q <= S_FAIL;
                    end
                end
                S_FAIL: begin
                    card_pwr_en <= 1'b0;
                    card_clk_en <= 1'b0;
                    sig18_en    <= 1'b0;
                    retry_q     <= 1'b1;
                    done        <= 1'b1;
                    res_q       <= RES_RETRY;
                    state_q     <= S_IDLE;
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    assign status = res_q;
endmodule

// File: rtl/sd_vswitch_seq_chk.sv
module sd_vswitch_seq_chk (
    input logic        clk,
    input logic        rst,
    input logic        done,
    input logic [1:0]  status,
    input logic        card_pwr_en,
    input logic        card_clk_en,
    input logic        sig18_en,
    input logic        cmd_req,
    input logic        cmd_ack,
    input logic [5:0]  cmd_idx,
    input logic [31:0] cmd_arg
);
    AST_DONE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R10
    AST_DONE_HAS_RESULT: assert property (@(posedge clk) disable iff (rst)
        done |-> (status != 2'b00)); // R10
    AST_ENABLE_WHILE_GATED: assert property (@(posedge clk) disable iff (rst)
        $rose(sig18_en) |-> !card_clk_en); // R7
    AST_SWITCH_ARG_ZERO: assert property (@(posedge clk) disable iff (rst)
        (cmd_req && cmd_idx == 6'd11) |-> (cmd_arg == 32'h0)); // R5
    AST_RETRY_POWER_OFF: assert property (@(posedge clk) disable iff (rst)
        (done && status == 2'b10) |-> (!card_pwr_en && !card_clk_en && !sig18_en)); // R9
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (cmd_req && !cmd_ack) |=> (cmd_req && $stable(cmd_idx))); // R3
endmodule

bind sd_vswitch_seq sd_vswitch_seq_chk u_chk (
    .clk(clk), .rst(rst), .done(done), .status(status),
    .card_pwr_en(card_pwr_en), .card_clk_en(card_clk_en), .sig18_en(sig18_en),
    .cmd_req(cmd_req), .cmd_ack(cmd_ack), .cmd_idx(cmd_idx), .cmd_arg(cmd_arg)
);

// File: tb/sd_vswitch_seq_tb.sv
module sd_vswitch_seq_tb;
    localparam int CPM = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        spi_mode = 1'b0;
    logic [2:0]  uhs_cap = 3'b000;
    logic [2:0]  rail_cap = 3'b001;
    logic [23:0] max_cur = 24'h0;
    logic        cmd_req;
    logic [5:0]  cmd_idx;
    logic [31:0] cmd_arg;
    logic        cmd_ack = 1'b0;
    logic        cmd_err = 1'b0;
    logic [31:0] cmd_resp = 32'h0;
    logic        card_clk_en, card_pwr_en, sig18_en, done;
    logic        v18_good = 1'b1;
    logic [3:0]  dat_lvl;
    logic [1:0]  status;

    logic [31:0] resp41 = 32'h0, resp11 = 32'h0;
    logic        err41 = 1'b0, err11 = 1'b0;
    logic [3:0]  dat_off = 4'h0, dat_on = 4'hF;
    logic [31:0] arg41_seen = 32'h0, arg11_seen = 32'hFFFF_FFFF;
    int          n11 = 0;
    int          dly = 0;
    int          checks = 0, fails = 0, cycles = 0;
    logic [1:0]  st_at_done;
    logic        pwr_at_done, clk_at_done, s18_at_done;

    assign dat_lvl = card_clk_en ? dat_on : dat_off;

    always #4 clk = ~clk;

    sd_vswitch_seq #(.CYC_PER_MS(CPM)) u_dut (
        .clk(clk), .rst(rst), .start(start), .spi_mode(spi_mode),
        .uhs_cap(uhs_cap), .rail_cap(rail_cap), .max_cur(max_cur),
        .cmd_req(cmd_req), .cmd_idx(cmd_idx), .cmd_arg(cmd_arg),
        .cmd_ack(cmd_ack), .cmd_err(cmd_err), .cmd_resp(cmd_resp),
        .card_clk_en(card_clk_en), .card_pwr_en(card_pwr_en), .sig18_en(sig18_en),
        .v18_good(v18_good), .dat_lvl(dat_lvl), .done(done), .status(status)
    );

    // Card / command engine model
    always @(negedge clk) begin
        cmd_ack <= 1'b0;
        if (cmd_req && !cmd_ack) begin
            if (dly == 2) begin
                dly = 0;
                cmd_ack <= 1'b1;
                if (cmd_idx == 6'd41) begin
                    arg41_seen = cmd_arg; cmd_resp <= resp41; cmd_err <= err41;
                end else begin
                    arg11_seen = cmd_arg; cmd_resp <= resp11; cmd_err <= err11; n11++;
                end
            end else dly++;
        end else dly = 0;
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                fails++; checks++;
                $display("FAIL watchdog: actual hung expected finish");
                $display("%0d/%0d checks passed", checks - fails, checks);
                $finish;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_arg(input logic s18, input logic xpc);
        logic [31:0] a;
        a = 32'h4000_0000;
        if (rail_cap[0]) a |= 32'h0030_0000;
        if (rail_cap[1]) a |= 32'h0006_0000;
        if (rail_cap[2]) a |= 32'h0000_0080;
        a[24] = s18;
        a[28] = xpc;
        return a;
    endfunction

    task automatic attempt();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        for (int i = 0; i < 2000; i++) begin
            if (done) break;
            @(negedge clk);
        end
        st_at_done = status; pwr_at_done = card_pwr_en;
        clk_at_done = card_clk_en; s18_at_done = sig18_en;
        chk("R10 done seen", {31'h0, done}, 32'h1);
        @(negedge clk);
        chk("R10 single pulse", {31'h0, done}, 32'h0);
    endtask

    task automatic t_reset();
        chk("R1 pwr", {31'h0, card_pwr_en}, 32'h1);
        chk("R1 clk", {31'h0, card_clk_en}, 32'h1);
        chk("R1 sig18", {31'h0, sig18_en}, 32'h0);
        chk("R1 req/done", {30'h0, cmd_req, done}, 32'h0);
    endtask

    task automatic t_xpc();
        uhs_cap = 3'b000; rail_cap = 3'b001; max_cur = 24'h00_0026; resp41 = 32'h4000_0000;
        n11 = 0; attempt();
        chk("R3 xpc 152mA", arg41_seen, exp_arg(1'b0, 1'b1));
        chk("R2 no uhs no s18r", {31'h0, arg41_seen[24]}, 32'h0);
        chk("R4 no switch ok", {30'h0, st_at_done}, 32'h1);
        max_cur = 24'h00_0025; attempt();
        chk("R3 xpc 148mA", arg41_seen, exp_arg(1'b0, 1'b0));
        rail_cap = 3'b110; max_cur = 24'h25_2500 | 24'h00_00FF; attempt();
        chk("R3 strong field but rail off", arg41_seen, exp_arg(1'b0, 1'b0));
        rail_cap = 3'b100; max_cur = 24'h26_0000; attempt();
        chk("R3 1.8V rail strong", arg41_seen, exp_arg(1'b0, 1'b1));
        chk("R4 no cmd11", n11, 0);
        rail_cap = 3'b001; max_cur = 24'h0;
    endtask

    task automatic t_success();
        int off_cnt, on_cnt;
        uhs_cap = 3'b010; resp41 = 32'h41FF_8000; resp11 = 32'h0000_0900;
        dat_off = 4'h0; dat_on = 4'hF; v18_good = 1'b1; n11 = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        for (int i = 0; i < 2000 && !sig18_en; i++) @(negedge clk);
        chk("R7 enable with clock off", {31'h0, card_clk_en}, 32'h0);
        off_cnt = 0;
        while (!card_clk_en && off_cnt < 1000) begin off_cnt++; @(negedge clk); end
        chk("R7 gated window", off_cnt, 5 * CPM);
        on_cnt = 0;
        while (!done && on_cnt < 1000) begin on_cnt++; @(negedge clk); end
        chk("R8 restored window", on_cnt, CPM);
        chk("R8 status ok", {30'h0, status}, 32'h1);
        chk("R8 sig18 kept", {29'h0, sig18_en, card_clk_en, card_pwr_en}, 32'h7);
        chk("R2 s18r sent", arg41_seen, exp_arg(1'b1, 1'b0));
        chk("R5 cmd11 arg zero", arg11_seen, 32'h0);
        chk("R5 one cmd11", n11, 1);
        @(negedge clk);
    endtask

    task automatic t_no_accept();
        uhs_cap = 3'b001; n11 = 0;
        resp41 = 32'h4000_0000; attempt();
        chk("R4 ccs only", {30'h0, st_at_done}, 32'h1);
        resp41 = 32'h0100_0000; attempt();
        chk("R4 s18a only", {30'h0, st_at_done}, 32'h1);
        resp41 = 32'h4100_0000; spi_mode = 1'b1; attempt();
        chk("R4 spi mode", {30'h0, st_at_done}, 32'h1);
        spi_mode = 1'b0;
        chk("R4 no cmd11 issued", n11, 0);
        chk("R4 clock kept", {31'h0, clk_at_done}, 32'h1);
    endtask

    task automatic t_fail(input string tag, input logic [3:0] off, input logic [3:0] on, input logic good);
        uhs_cap = 3'b100; resp41 = 32'h4100_0000; resp11 = 32'h0;
        dat_off = off; dat_on = on; v18_good = good;
        attempt();
        chk({tag, " retry status"}, {30'h0, st_at_done}, 32'h2);
        chk("R9 powered down", {29'h0, pwr_at_done, clk_at_done, s18_at_done}, 32'h0);
        dat_off = 4'h0; dat_on = 4'hF; v18_good = 1'b1;
        resp41 = 32'h4000_0000; attempt();
        chk("R9 retry clears s18r", {31'h0, arg41_seen[24]}, 32'h0);
        chk("R9 retry ok", {30'h0, st_at_done}, 32'h1);
        attempt();
        chk("R9 ok clears pending", {31'h0, arg41_seen[24]}, 32'h1);
    endtask

    task automatic t_cmd_err();
        uhs_cap = 3'b001; resp41 = 32'h4100_0000; resp11 = 32'h0008_0000;
        attempt();
        chk("R5 r1 error bit", {30'h0, st_at_done}, 32'h3);
        chk("R5 power kept", {31'h0, pwr_at_done}, 32'h1);
        resp11 = 32'h0; err41 = 1'b1; attempt();
        chk("R5 cmd41 transport error", {30'h0, st_at_done}, 32'h3);
        err41 = 1'b0; err11 = 1'b1; attempt();
        chk("R5 cmd11 transport error", {30'h0, st_at_done}, 32'h3);
        err11 = 1'b0;
        attempt();
        chk("R5 error leaves s18r", {31'h0, arg41_seen[24]}, 32'h1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_xpc();
        t_success();
        t_no_accept();
        t_fail("R6 dat not low", 4'h2, 4'hF, 1'b1);
        t_fail("R7 regulator dropped", 4'h0, 4'hF, 1'b0);
        t_fail("R8 dat not high", 4'h0, 4'h7, 1'b1);
        t_cmd_err();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule